// File: doc/BRIEF.md
# Wired-AND Bus Clock Synchronizer

This block produces the serial clock of a master on a two-wire bus whose clock line is a wired-AND. Any device that pulls the line low forces it low for every device. The block never drives the line high. It either requests a pull-low or lets go. Its timing is set by the line level it observes, not by its own request. The low phase restarts on every observed falling edge, whoever caused it. The high phase starts counting only once the line is seen high. As a result, the shared clock follows the longest low period and the shortest high period among all participants. A slave that holds the line low longer than the master's low count stretches the bit.

The clock line level arrives already filtered and synchronized. The block has two programmable phase lengths, in system clock cycles. Each length is captured when its phase begins. While the block has released the line but still sees it held low, it raises a wait flag.

Top module: `bus_clk_sync`

## Requirements
- R1: While `enable` is low, `scl_pull_low` is 0 and `clk_wait` is 0 from the next cycle on, even if the line is held low externally.
- R2: In the cycle after `enable` is first seen high in idle, `scl_pull_low` is 1, which begins a low phase.
- R3: A low phase requests the pull-low for exactly max(`low_count`,1) cycles. A value of 0 is treated as 1.
- R4: After releasing, the block waits without counting while the line stays low. `clk_wait` (1 = waiting) is 1 in every such cycle, so the observed low time is the longer of its own and any other device's hold.
- R5: High counting starts at the first clock edge where the line is seen high. After max(`high_count`,1) counted cycles, the block requests the pull-low again. With no outside hold, the observed high time is max(`high_count`,1)+1 cycles.
- R6: A line falling edge seen during high counting ends the high phase at once. `scl_pull_low` is 1 in the next cycle and stays 1 for a full max(`low_count`,1) cycles.
- R7: `low_count` and `high_count` are captured when their phase begins. A change made during a phase affects only a later phase.

Top-module signal encodings: `scl_pull_low` = 1 means pull the line low. `scl_in` = 1 means the line is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run the clock generator; low forces idle and releases the line |
| scl_in | input | 1 | Filtered clock line level (1 = high) |
| low_count | input | CNT_W | Low phase length in cycles (0 acts as 1) |
| high_count | input | CNT_W | High phase length in cycles (0 acts as 1) |
| scl_pull_low | output | 1 | Open-drain request: 1 pulls the clock line low |
| clk_wait | output | 1 | 1 while the line is released but still observed low |

## Verification
The hardest case to reach from the ports is a falling edge that another device causes in the middle of this block's high count. Hitting it needs a second driver on the wired line, timed so that it fires after the line has been seen high but before the block's own count ends. The bench models the wired-AND line itself, combining the block's request with a counting slave that stretches the low phase by a set number of cycles. It sweeps low length, high length and stretch over a small grid. It also injects a one-cycle external pull in the second cycle of a long high phase to force the abort path.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_LOW   = 2'd1,
    PH_HWAIT = 2'd2,
    PH_HIGH  = 2'd3
  } phase_t;
endpackage

// File: rtl/bcs_phase_ctr.sv
module bcs_phase_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  output logic [W-1:0] count,
  output logic         done
);
  localparam logic [W-1:0] ONE = W'(1);

  // phase length: a programmed zero still gives one cycle
  function automatic logic [W-1:0] phase_len(input logic [W-1:0] v);
    return (v == '0) ? ONE : v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= ONE;
    else if (load) count <= phase_len(load_val);
    else if (step) count <= count - ONE;
  end

  assign done = (count <= ONE);

  // R3: the counter is never stepped past its last cycle
  p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> !done);
  p_load_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> count != '0);
endmodule

// File: rtl/bcs_phase_fsm.sv
module bcs_phase_fsm
  import bcs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic scl_in,
  input  logic cnt_done,
  output logic load_low,
  output logic load_high,
  output logic step,
  output logic in_low,
  output logic in_hwait,
  output logic in_high
);
  phase_t ph, ph_nxt;
  logic   line_fall_seen;

  assign in_low         = (ph == PH_LOW);
  assign in_hwait       = (ph == PH_HWAIT);
  assign in_high        = (ph == PH_HIGH);
  assign line_fall_seen = in_high && !scl_in;

  always_comb begin
    ph_nxt    = ph;
    load_low  = 1'b0;
    load_high = 1'b0;
    step      = 1'b0;
    if (!enable) begin
      ph_nxt = PH_IDLE;
    end else begin
      unique case (ph)
        PH_IDLE: begin
          ph_nxt   = PH_LOW;
          load_low = 1'b1;
        end
        PH_LOW: begin
          if (cnt_done) ph_nxt = PH_HWAIT;
          else          step   = 1'b1;
        end
        PH_HWAIT: begin
          if (scl_in) begin
            ph_nxt    = PH_HIGH;
            load_high = 1'b1;
          end
        end
        PH_HIGH: begin
          if (line_fall_seen || cnt_done) begin
            ph_nxt   = PH_LOW;
            load_low = 1'b1;
          end else begin
            step = 1'b1;
          end
        end
        default: ph_nxt = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph <= PH_IDLE;
    else        ph <= ph_nxt;
  end

  p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !in_low);
  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_IDLE) && enable |=> in_low);
  p_wait_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_hwait && !scl_in && enable |=> in_hwait);
  p_high_after_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_high) |-> $past(scl_in));
  p_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
    line_fall_seen && enable |=> in_low);
  p_one_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({in_low, in_hwait, in_high}));
endmodule

// File: rtl/bus_clk_sync.sv
module bus_clk_sync #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             scl_in,
  input  logic [CNT_W-1:0] low_count,
  input  logic [CNT_W-1:0] high_count,
  output logic             scl_pull_low,
  output logic             clk_wait
);
  logic             load_low, load_high, step, cnt_done;
  logic             in_low, in_hwait, in_high;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] load_val;

  assign load_val = load_low ? low_count : high_count;

  bcs_phase_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .scl_in    (scl_in),
    .cnt_done  (cnt_done),
    .load_low  (load_low),
    .load_high (load_high),
    .step      (step),
    .in_low    (in_low),
    .in_hwait  (in_hwait),
    .in_high   (in_high)
  );

  bcs_phase_ctr #(.W(CNT_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_low | load_high),
    .load_val (load_val),
    .step     (step),
    .count    (cnt),
    .done     (cnt_done)
  );

  assign scl_pull_low = in_low;
  assign clk_wait     = in_hwait && !scl_in;

  p_wait_released_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clk_wait |-> !scl_pull_low);
  p_disabled_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !scl_pull_low && !clk_wait);
  p_high_no_pull_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_high |-> !scl_pull_low && cnt != '0);
endmodule

// File: tb/bus_clk_sync_test.sv
module bus_clk_sync_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic [7:0] low_count = 8'd3;
  logic [7:0] high_count = 8'd2;
  logic       slave_hold = 1'b0;
  logic       ext_force = 1'b0;
  logic       scl_pull_low, clk_wait;
  wire        line = ~(scl_pull_low | slave_hold | ext_force);

  int stretch = 0;
  int slave_run = 0;
  logic slave_prev = 1'b1;
  int n_checks = 0;
  int n_fail = 0;
  bit timed_out = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_clk_sync uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .scl_in(line),
    .low_count(low_count), .high_count(high_count),
    .scl_pull_low(scl_pull_low), .clk_wait(clk_wait)
  );

  // slave model: holds the line low until it has seen `stretch` low samples
  always @(negedge clk) begin
    if (slave_prev && !line) begin
      slave_run  <= 1;
      slave_hold <= (1 < stretch);
    end else if (!line) begin
      slave_run  <= slave_run + 1;
      slave_hold <= (slave_run + 1 < stretch);
    end else begin
      slave_hold <= 1'b0;
    end
    slave_prev <= line;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic to_fall();
    logic pl;
    do begin
      pl = line;
      @(negedge clk);
    end while (!(pl && !line));
  endtask

  // starts at a sample where the line has just fallen; ends at the next fall
  task automatic measure(output int lo, output int hi, output int fl);
    lo = 0; hi = 0; fl = 0;
    while (!line) begin
      lo++;
      fl += int'(clk_wait);
      @(negedge clk);
    end
    while (line) begin
      hi++;
      @(negedge clk);
    end
  endtask

  initial begin
    int lo, hi, fl, n;
    #(CLK_PERIOD * 3 + 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset pull", int'(scl_pull_low), 0);
    chk("R1 reset wait", int'(clk_wait), 0);

    // R2: start of a low phase
    enable = 1'b1;
    @(negedge clk);
    chk("R2 start low", int'(scl_pull_low), 1);

    // R1: disable mid low phase, line held externally
    enable = 1'b0;
    ext_force = 1'b1;
    @(negedge clk);
    chk("R1 disable pull", int'(scl_pull_low), 0);
    for (int i = 0; i < 4; i++) begin
      chk("R1 disabled wait", int'(clk_wait), 0);
      @(negedge clk);
    end
    ext_force = 1'b0;
    @(negedge clk);
    enable = 1'b1;

    // R3 R4 R5: sweep low, high and stretch lengths
    for (int l = 0; l <= 4; l++) begin
      for (int h = 0; h <= 4; h++) begin
        for (int s = 0; s <= 7; s++) begin
          int le, he;
          le = (l == 0) ? 1 : l;
          he = (h == 0) ? 1 : h;
          to_fall();
          low_count  = 8'(l);
          high_count = 8'(h);
          stretch    = s;
          measure(lo, hi, fl);
          measure(lo, hi, fl);
          chk("R3/R4 low time", lo, (s > le) ? s : le);
          chk("R4 wait cycles", fl, (s > le) ? s - le : 0);
          chk("R5 high time", hi, (s > le) ? he : he + 1);
        end
      end
    end

    // R7: counts captured at phase start
    stretch = 0; low_count = 8'd3; high_count = 8'd2;
    to_fall();
    measure(lo, hi, fl);
    low_count = 8'd6;
    measure(lo, hi, fl);
    chk("R7 current low kept", lo, 3);
    measure(lo, hi, fl);
    chk("R7 next low new", lo, 6);

    // R6: external fall during the high count
    low_count = 8'd3; high_count = 8'd8;
    to_fall();
    while (!line) @(negedge clk);
    @(negedge clk);
    ext_force = 1'b1;
    @(negedge clk);
    ext_force = 1'b0;
    chk("R6 abort to low", int'(scl_pull_low), 1);
    n = 0;
    while (scl_pull_low && n < 50) begin
      n++;
      @(negedge clk);
    end
    chk("R6 full low after abort", n, 3);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    timed_out = 1'b1;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule